// File: doc/BRIEF.md
# Vector Compare to Predicate Mask

This block executes a branch-type comparison whose two source operands may each be marked as a vector. When neither source carries the vector mark, it behaves as a plain conditional branch: it reads one register per source, evaluates the condition and reports a taken or not-taken decision. When at least one source is a vector, the same comparison runs element by element over the current vector length. The result is a bit mask, bit i holding the outcome for element i, which is written into an integer register that serves as a predicate.

A vector source supplies register base+i for element i. A scalar source supplies its base register to every element, so a scalar is broadcast against a vector. The block drives the address of a two-port register read interface and compares the returned data in the same cycle, one element per cycle. The finished mask leaves through a single write strobe with its destination register number. The register file and the computation of branch targets sit outside the block.

Top module: `vec_cmp_pred`

## Requirements
- R1: A start is sampled at a rising edge while idle. A scalar-scalar result appears after the next edge. A vector result appears after max(VLe,1) further edges, where VLe is the effective length. Each result strobe lasts exactly one cycle.
- R2: When both vector flags are clear, br_valid pulses with br_taken equal to the condition on rf[src1] and rf[src2], and pw_en stays low.
- R3: When either vector flag is set, exactly one pw_en pulse is produced with bit i of pw_mask equal to the condition on element pair i, and br_valid stays low.
- R4: For element i, a vector source reads register (base+i) modulo NREG and a scalar source reads its base register for every element.
- R5: Every pw_mask bit at a position of VLe or above is zero.
- R6: Condition codes: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Codes 010 and 011 never hold.
- R7: A vector operation with VL of zero writes an all-zero mask one edge after the edge that sampled start.
- R8: A VL above XLEN is treated as XLEN.
- R9: A start raised while busy is ignored, and the running operation finishes with its own operands, condition and destination.
- R10: busy is high from the accepting edge until the result edge and low during the result cycle. A start presented in that cycle is accepted.
- R11: pw_addr equals the destination register given with start, and done is high exactly when pw_en is high.
- R12: While reset is held, busy, br_valid, pw_en and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue request for one compare operation |
| cond | input | 3 | Condition code (see R6) |
| src1_idx | input | $clog2(NREG) | Base register of first source |
| src1_vec | input | 1 | First source is a vector |
| src2_idx | input | $clog2(NREG) | Base register of second source |
| src2_vec | input | 1 | Second source is a vector |
| pdst | input | $clog2(NREG) | Register receiving the predicate mask |
| vl | input | $clog2(XLEN+1) | Vector length |
| rf_addr1 | output | $clog2(NREG) | Read address, first source |
| rf_data1 | input | XLEN | Read data, first source (same cycle) |
| rf_addr2 | output | $clog2(NREG) | Read address, second source |
| rf_data2 | input | XLEN | Read data, second source (same cycle) |
| busy | output | 1 | Operation in progress |
| br_valid | output | 1 | Scalar branch decision valid |
| br_taken | output | 1 | Scalar branch decision |
| pw_en | output | 1 | Predicate register write strobe |
| pw_addr | output | $clog2(NREG) | Predicate register number |
| pw_mask | output | XLEN | Predicate mask value |
| done | output | 1 | Vector operation complete |

## Verification
Result delivery and acceptance of the next operation can land in the same cycle, because busy falls in the cycle that carries the pw_en or br_valid strobe. The bench provokes this by raising start at the very sample point where it sees a result strobe. It then checks the delivered result against its own model, checks that busy is low there, and checks that the follow-on operation returns its own correct value with the normal latency counted from that cycle. Collision with a start raised mid-run is provoked separately: the second request carries different operands, and the first operation's mask, destination and latency must come out unchanged.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    // Compare condition codes; 3'b010 and 3'b011 are unused and never hold
    typedef enum logic [2:0] {
        CC_EQ  = 3'b000,
        CC_NE  = 3'b001,
        CC_LT  = 3'b100,
        CC_GE  = 3'b101,
        CC_LTU = 3'b110,
        CC_GEU = 3'b111
    } cc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAL = 2'd1,
        ST_RUN  = 2'd2
    } st_e;

    localparam int NSRC = 2;

    function automatic logic cc_defined(input logic [2:0] c);
        return (c != 3'b010) && (c != 3'b011);
    endfunction

endpackage

// File: rtl/vcmp_cmp.sv
module vcmp_cmp
    import vcmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      cc,
    output logic            hit
);

    logic eq, lts, ltu, raw;

    always_comb begin
        eq  = (a == b);
        lts = ($signed(a) < $signed(b));
        ltu = (a < b);
        case (cc_e'(cc))
            CC_EQ:   raw = eq;
            CC_NE:   raw = !eq;
            CC_LT:   raw = lts;
            CC_GE:   raw = !lts;
            CC_LTU:  raw = ltu;
            CC_GEU:  raw = !ltu;
            default: raw = 1'b0;
        endcase
        hit = raw && cc_defined(cc);
    end

endmodule

// File: rtl/vcmp_seq.sv
module vcmp_seq
    import vcmp_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VLW  = 6,
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            any_vec,
    input  logic [VLW-1:0]  vl,
    output st_e             state,
    output logic [IDXW-1:0] idx,
    output logic [VLW-1:0]  vl_r,
    output logic            accept,
    output logic            elem_en,
    output logic            last,
    output logic            busy
);

    logic [VLW-1:0] vl_clamp;

    always_comb begin
        vl_clamp = (vl > VLW'(XLEN)) ? VLW'(XLEN) : vl;
        accept   = (state == ST_IDLE) && start;
        busy     = (state != ST_IDLE);
        elem_en  = (state == ST_RUN) && (VLW'(idx) < vl_r);
        last     = (state == ST_RUN) && ((VLW'(idx) + VLW'(1)) >= vl_r);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            vl_r  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_r  <= vl_clamp;
                        idx   <= '0;
                        state <= any_vec ? ST_RUN : ST_SCAL;
                    end
                end
                ST_SCAL: state <= ST_IDLE;
                ST_RUN: begin
                    if (last) state <= ST_IDLE;
                    else      idx   <= idx + IDXW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: captured length never exceeds XLEN
    p_len_clamped_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (vl_r <= VLW'(XLEN)));

    // R5: the element index stays inside the effective length
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> ((VLW'(idx) < vl_r) || (vl_r == '0 && idx == '0)));

endmodule

// File: rtl/vcmp_src_addr.sv
module vcmp_src_addr #(
    parameter int RAW  = 5,
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [RAW-1:0]  base,
    input  logic            vec,
    input  logic [IDXW-1:0] idx,
    output logic [RAW-1:0]  addr
);

    always_comb addr = vec ? (base + RAW'(idx)) : base;

    // R4: a vector source walks one register per element, wrapping modulo NREG
    p_vec_step_r4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && vec) |-> (addr == RAW'($past(addr) + RAW'(1))));

    // R4: a scalar source keeps one register for the whole run
    p_scal_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !vec) |-> $stable(addr));

endmodule

// File: rtl/vcmp_mask_acc.sv
module vcmp_mask_acc #(
    parameter int XLEN = 32,
    parameter int IDXW = 5,
    parameter int VLW  = 6,
    parameter int RAW  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            elem_en,
    input  logic            hit,
    input  logic            last,
    input  logic            scal_fire,
    input  logic [IDXW-1:0] idx,
    input  logic [VLW-1:0]  vl_r,
    input  logic [RAW-1:0]  dst,
    output logic            pw_en,
    output logic [RAW-1:0]  pw_addr,
    output logic [XLEN-1:0] pw_mask,
    output logic            done,
    output logic            br_valid,
    output logic            br_taken
);

    logic [XLEN-1:0] acc;
    logic [XLEN-1:0] bitsel;

    always_comb bitsel = (elem_en && hit) ? (XLEN'(1) << idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            pw_en    <= 1'b0;
            pw_addr  <= '0;
            pw_mask  <= '0;
            done     <= 1'b0;
            br_valid <= 1'b0;
            br_taken <= 1'b0;
        end else begin
            if (clear) acc <= '0;
            else       acc <= acc | bitsel;
            pw_en <= last;
            done  <= last;
            if (last) begin
                pw_mask <= acc | bitsel;
                pw_addr <= dst;
            end
            br_valid <= scal_fire;
            br_taken <= scal_fire && hit;
        end
    end

    // R5: no bit at or above the effective length reaches the predicate
    p_mask_clear_high_r5: assert property (@(posedge clk) disable iff (rst)
        pw_en |-> ((pw_mask >> vl_r) == '0));

    // R2/R3: a branch decision and a predicate write never share a cycle
    p_one_kind_r3: assert property (@(posedge clk) disable iff (rst)
        !(pw_en && br_valid));

endmodule

// File: rtl/vec_cmp_pred.sv
module vec_cmp_pred
    import vcmp_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW  = $clog2(NREG),
    localparam int VLW  = $clog2(XLEN + 1),
    localparam int IDXW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      cond,
    input  logic [RAW-1:0]  src1_idx,
    input  logic            src1_vec,
    input  logic [RAW-1:0]  src2_idx,
    input  logic            src2_vec,
    input  logic [RAW-1:0]  pdst,
    input  logic [VLW-1:0]  vl,
    output logic [RAW-1:0]  rf_addr1,
    input  logic [XLEN-1:0] rf_data1,
    output logic [RAW-1:0]  rf_addr2,
    input  logic [XLEN-1:0] rf_data2,
    output logic            busy,
    output logic            br_valid,
    output logic            br_taken,
    output logic            pw_en,
    output logic [RAW-1:0]  pw_addr,
    output logic [XLEN-1:0] pw_mask,
    output logic            done
);

    st_e                         state;
    logic [IDXW-1:0]             idx;
    logic [VLW-1:0]              vl_r;
    logic                        accept, elem_en, last, hit;
    logic [NSRC-1:0][RAW-1:0]    base_in, base_r, rd_addr;
    logic [NSRC-1:0]             vec_in, vec_r;
    logic [2:0]                  cc_r;
    logic [RAW-1:0]              dst_r;

    assign base_in = {src2_idx, src1_idx};
    assign vec_in  = {src2_vec, src1_vec};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_r <= '0;
            vec_r  <= '0;
            cc_r   <= '0;
            dst_r  <= '0;
        end else if (accept) begin
            base_r <= base_in;
            vec_r  <= vec_in;
            cc_r   <= cond;
            dst_r  <= pdst;
        end
    end

    vcmp_seq #(.XLEN(XLEN), .VLW(VLW), .IDXW(IDXW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .any_vec (|vec_in),
        .vl      (vl),
        .state   (state),
        .idx     (idx),
        .vl_r    (vl_r),
        .accept  (accept),
        .elem_en (elem_en),
        .last    (last),
        .busy    (busy)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        vcmp_src_addr #(.RAW(RAW), .IDXW(IDXW)) u_addr (
            .clk  (clk),
            .rst  (rst),
            .run  (state == ST_RUN),
            .base (base_r[g]),
            .vec  (vec_r[g]),
            .idx  (idx),
            .addr (rd_addr[g])
        );
    end

    assign rf_addr1 = rd_addr[0];
    assign rf_addr2 = rd_addr[1];

    vcmp_cmp #(.XLEN(XLEN)) u_cmp (
        .a   (rf_data1),
        .b   (rf_data2),
        .cc  (cc_r),
        .hit (hit)
    );

    vcmp_mask_acc #(.XLEN(XLEN), .IDXW(IDXW), .VLW(VLW), .RAW(RAW)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .elem_en   (elem_en),
        .hit       (hit),
        .last      (last),
        .scal_fire (state == ST_SCAL),
        .idx       (idx),
        .vl_r      (vl_r),
        .dst       (dst_r),
        .pw_en     (pw_en),
        .pw_addr   (pw_addr),
        .pw_mask   (pw_mask),
        .done      (done),
        .br_valid  (br_valid),
        .br_taken  (br_taken)
    );

    // R9: a start seen while busy leaves the captured operation untouched
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(cc_r) && $stable(dst_r) && $stable(vec_r) && $stable(base_r)));

    // R10: every result cycle is a cycle in which a new start can be taken
    p_result_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (pw_en || br_valid) |-> !busy);

    // R11: done travels with the predicate write
    p_done_write_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> (pw_en && !$past(state == ST_SCAL)));

endmodule

// File: tb/vec_cmp_pred_tb_top.sv
module vec_cmp_pred_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  cond;
    logic [4:0]  src1_idx, src2_idx, pdst;
    logic        src1_vec, src2_vec;
    logic [5:0]  vl;
    logic [4:0]  rf_addr1, rf_addr2;
    logic [31:0] rf_data1, rf_data2;
    logic        busy, br_valid, br_taken, pw_en, done;
    logic [4:0]  pw_addr;
    logic [31:0] pw_mask;

    logic [31:0] rf [0:31];
    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_data1 = rf[rf_addr1];
    assign rf_data2 = rf[rf_addr2];

    vec_cmp_pred dut_i (
        .clk(clk), .rst(rst), .start(start), .cond(cond),
        .src1_idx(src1_idx), .src1_vec(src1_vec),
        .src2_idx(src2_idx), .src2_vec(src2_vec),
        .pdst(pdst), .vl(vl),
        .rf_addr1(rf_addr1), .rf_data1(rf_data1),
        .rf_addr2(rf_addr2), .rf_data2(rf_data2),
        .busy(busy), .br_valid(br_valid), .br_taken(br_taken),
        .pw_en(pw_en), .pw_addr(pw_addr), .pw_mask(pw_mask), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // R6 condition model
    function automatic bit f_cmp(input logic [2:0] cc, input logic [31:0] a, input logic [31:0] b);
        case (cc)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b100:  return $signed(a) < $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a < b;
            3'b111:  return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int f_vle(input logic [5:0] v);
        return (v > 6'd32) ? 32 : int'(v);
    endfunction

    // R3/R4/R5/R8 mask model
    function automatic logic [31:0] f_mask(input logic [2:0] cc, input logic [4:0] b1, input bit v1,
                                           input logic [4:0] b2, input bit v2, input logic [5:0] v);
        logic [31:0] m;
        logic [4:0]  ia, ib;
        m = '0;
        for (int i = 0; i < f_vle(v); i++) begin
            ia = v1 ? b1 + 5'(i) : b1;
            ib = v2 ? b2 + 5'(i) : b2;
            if (f_cmp(cc, rf[ia], rf[ib])) m[i] = 1'b1;
        end
        return m;
    endfunction

    task automatic issue(input logic [2:0] cc, input logic [4:0] b1, input bit v1,
                         input logic [4:0] b2, input bit v2, input logic [4:0] d, input logic [5:0] v);
        cond = cc; src1_idx = b1; src1_vec = v1; src2_idx = b2; src2_vec = v2; pdst = d; vl = v;
        start = 1'b1;
    endtask

    task automatic await_chk(input logic [2:0] cc, input logic [4:0] b1, input bit v1,
                             input logic [4:0] b2, input bit v2, input logic [4:0] d,
                             input logic [5:0] v, input int cnt0, input string tag);
        int cnt;
        bit sc;
        int lat;
        logic [31:0] em;
        bit et;
        cnt = cnt0;
        sc  = !v1 && !v2;
        lat = sc ? 2 : ((f_vle(v) == 0) ? 2 : f_vle(v) + 1);
        em  = f_mask(cc, b1, v1, b2, v2, v);
        et  = f_cmp(cc, rf[b1], rf[b2]);
        do begin
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end while (!(pw_en || br_valid) && cnt < 80);
        chk(cnt == lat, {tag, " R1 latency"}, 64'(cnt), 64'(lat));
        chk(!busy, {tag, " R10 busy low in result cycle"}, 64'(busy), 64'd0);
        if (sc) begin
            chk(br_valid && !pw_en && !done, {tag, " R2 branch strobe only"},
                {pw_en, br_valid}, 2'b01);
            chk(br_taken == et, {tag, " R2 taken"}, 64'(br_taken), 64'(et));
        end else begin
            chk(pw_en && done && !br_valid, {tag, " R11 write with done"},
                {br_valid, pw_en, done}, 3'b011);
            chk(pw_mask == em, {tag, " R3 mask"}, 64'(pw_mask), 64'(em));
            chk(pw_addr == d, {tag, " R11 dest"}, 64'(pw_addr), 64'(d));
        end
    endtask

    task automatic run_op(input logic [2:0] cc, input logic [4:0] b1, input bit v1,
                          input logic [4:0] b2, input bit v2, input logic [4:0] d,
                          input logic [5:0] v, input string tag);
        issue(cc, b1, v1, b2, v2, d, v);
        await_chk(cc, b1, v1, b2, v2, d, v, 0, tag);
        @(negedge clk);
        chk(!pw_en && !br_valid && !done, {tag, " R1 one-cycle strobe"},
            {pw_en, br_valid, done}, 3'b000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; start = 1'b0; cond = '0; src1_idx = '0; src2_idx = '0;
        src1_vec = 1'b0; src2_vec = 1'b0; pdst = '0; vl = '0;
        for (int i = 0; i < 32; i++) rf[i] = $urandom;
        rf[1] = 32'd5; rf[2] = 32'd5; rf[3] = 32'd7;
        for (int i = 8; i < 16; i++) rf[i] = 32'(i - 12);
        for (int i = 16; i < 24; i++) rf[i] = 32'd1 << (i - 14);
        rf[20] = 32'hFFFF_FFF0;
        repeat (3) @(negedge clk);
        chk(!busy && !br_valid && !pw_en && !done, "R12 reset state",
            {busy, br_valid, pw_en, done}, 4'b0000);
        rst = 1'b0;
        @(negedge clk);

        // R2 scalar branch decisions
        run_op(3'b000, 5'd1, 0, 5'd2, 0, 5'd9, 6'd8, "R2 eq taken");
        run_op(3'b001, 5'd1, 0, 5'd2, 0, 5'd9, 6'd8, "R2 ne not taken");
        run_op(3'b110, 5'd1, 0, 5'd3, 0, 5'd9, 6'd8, "R2 ltu taken");
        // R3/R6 signed and unsigned vector-vector
        run_op(3'b100, 5'd8, 1, 5'd16, 1, 5'd4, 6'd8, "R6 vv signed lt");
        run_op(3'b110, 5'd8, 1, 5'd16, 1, 5'd4, 6'd8, "R6 vv unsigned lt");
        run_op(3'b101, 5'd8, 1, 5'd16, 1, 5'd4, 6'd8, "R6 vv signed ge");
        // R4 broadcast in either position
        run_op(3'b111, 5'd8, 1, 5'd1, 0, 5'd6, 6'd8, "R4 vector vs scalar geu");
        run_op(3'b100, 5'd3, 0, 5'd8, 1, 5'd6, 6'd8, "R4 scalar vs vector lt");
        // R4 wraparound of register numbers
        run_op(3'b001, 5'd30, 1, 5'd2, 0, 5'd7, 6'd5, "R4 wrap");
        // R7 zero length
        run_op(3'b000, 5'd1, 1, 5'd1, 1, 5'd12, 6'd0, "R7 vl zero");
        // R5 partial length
        run_op(3'b000, 5'd4, 1, 5'd4, 1, 5'd13, 6'd3, "R5 upper bits clear");
        // R8 length clamp: identical vectors, every bit set
        run_op(3'b000, 5'd0, 1, 5'd0, 1, 5'd14, 6'd40, "R8 clamp to xlen");
        run_op(3'b000, 5'd0, 1, 5'd0, 1, 5'd14, 6'd32, "R8 full length");
        // R6 undefined codes never hold
        run_op(3'b010, 5'd1, 1, 5'd1, 1, 5'd15, 6'd6, "R6 code 010");
        run_op(3'b011, 5'd1, 0, 5'd2, 0, 5'd15, 6'd6, "R6 code 011");

        // R9 start while busy is ignored
        issue(3'b100, 5'd8, 1, 5'd16, 1, 5'd21, 6'd6);
        @(negedge clk);
        issue(3'b000, 5'd1, 0, 5'd2, 0, 5'd3, 6'd2);
        await_chk(3'b100, 5'd8, 1, 5'd16, 1, 5'd21, 6'd6, 1, "R9 ignored start");
        @(negedge clk);
        chk(!pw_en && !br_valid && !busy, "R9 no second result",
            {pw_en, br_valid, busy}, 3'b000);

        // R10 back-to-back: issue in the result cycle
        issue(3'b110, 5'd16, 1, 5'd2, 0, 5'd22, 6'd3);
        await_chk(3'b110, 5'd16, 1, 5'd2, 0, 5'd22, 6'd3, 0, "R10 first");
        issue(3'b000, 5'd1, 0, 5'd2, 0, 5'd0, 6'd1);
        await_chk(3'b000, 5'd1, 0, 5'd2, 0, 5'd0, 6'd1, 0, "R10 second scalar");
        issue(3'b000, 5'd1, 1, 5'd1, 1, 5'd23, 6'd0);
        await_chk(3'b000, 5'd1, 1, 5'd1, 1, 5'd23, 6'd0, 0, "R10 third vl zero");
        issue(3'b001, 5'd8, 1, 5'd9, 1, 5'd24, 6'd4);
        await_chk(3'b001, 5'd8, 1, 5'd9, 1, 5'd24, 6'd4, 0, "R10 fourth");
        @(negedge clk);

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            logic [2:0] cc;
            logic [4:0] b1, b2, d;
            bit v1, v2;
            logic [5:0] v;
            for (int i = 0; i < 32; i++)
                rf[i] = ($urandom_range(0, 1) == 0) ? 32'($urandom_range(0, 3)) - 32'd1 : $urandom;
            cc = 3'($urandom_range(0, 7));
            b1 = 5'($urandom_range(0, 31));
            b2 = 5'($urandom_range(0, 31));
            d  = 5'($urandom_range(0, 31));
            v1 = 1'($urandom_range(0, 1));
            v2 = 1'($urandom_range(0, 1));
            v  = 6'($urandom_range(0, 40));
            run_op(cc, b1, v1, b2, v2, d, v, (v1 || v2) ? "R3 random" : "R2 random");
        end

        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule